// File: doc/BRIEF.md
# LCD Contrast and Power-Save Command Sequencer

This block sits behind the parallel 8-bit write port of a display controller and interprets the bytes a microcontroller writes to it. A byte is taken when the write strobe rises while chip select is active and the read strobe is idle. The A0 line decides whether the byte is a command (A0=0) or display data (A0=1). The block acts on four kinds of command byte:

- A contrast pair. An arming byte puts the block into a locked state. The very next command write is then stored, whatever its value, as a 6-bit contrast code.
- Two pairs of on/off commands. One pair drives the display-enable flag and the other drives the all-pixels-lit flag.
- Every other command byte is passed on unchanged as a one-cycle generic command strobe.

The block derives a power-save state from the two flags. Power save holds when the display is off and all-pixels-lit is on. In that state the oscillator and drive-supply enables drop and the driver outputs are forced low. Nothing else is lost: the contrast code and the display flag keep their values. The contrast code is also presented as an inverted drive level, where code 0 gives the highest level.

Top module: `lcdseq_top`

## Requirements
- R1: After a synchronous reset, the block is in this state: contrast code 6'h20, drive level 31, display off, all-pixels-lit off, not armed, no power save, oscillator and supply enabled, drivers not forced low, and no command strobe.
- R2: A write is accepted only on a rising edge of wrStrobe with csActive=1 and rdStrobe=0. A strobe held high for several cycles counts as one write. Writes made with csActive=0 or rdStrobe=1 have no effect.
- R3: Command byte 8'h81 arms contrast mode. The next accepted command write stores its bits 5:0 as the contrast code, ignores bits 7:6, and disarms the mode. Neither byte produces a command strobe.
- R4: While contrast mode is armed, every command byte is treated as contrast data. This includes 8'hAF and 8'h81. No other decode takes place and no command strobe is produced.
- R5: Data writes (A0=1) leave the armed state unchanged. A command write that follows them still loads the contrast code.
- R6: driveLevel always equals 63 minus the contrast code: 63 for code 0 and 0 for code 63.
- R7: Command 8'hAF sets displayOn and 8'hAE clears it. Command 8'hA5 sets allLit and 8'hA4 clears it. None of these four bytes produces a command strobe.
- R8: powerSave is 1 exactly when displayOn=0 and allLit=1. While it is 1, oscEnable=0, supplyEnable=0 and driversLow=1. Otherwise oscEnable=1, supplyEnable=1 and driversLow=0.
- R9: Every other command byte written while not armed raises cmdStrobe for exactly one cycle, with cmdByte equal to that byte.
- R10: Leaving power save through 8'hA4 keeps the contrast code and displayOn unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| csActive | input | 1 | Chip select, active high |
| wrStrobe | input | 1 | Write strobe; a rising edge marks a write |
| rdStrobe | input | 1 | Read strobe; a write is blocked while it is high |
| a0 | input | 1 | 0 = command byte, 1 = display data byte |
| dataIn | input | 8 | Written byte |
| contrastCode | output | 6 | Stored contrast code |
| driveLevel | output | 6 | Derived drive level (63 minus the code) |
| displayOn | output | 1 | Display enable flag |
| allLit | output | 1 | All-pixels-lit flag |
| powerSave | output | 1 | Power-save state |
| oscEnable | output | 1 | Oscillator enable |
| supplyEnable | output | 1 | Drive-supply enable |
| driversLow | output | 1 | Segment and common outputs forced low |
| cmdStrobe | output | 1 | One-cycle pulse for a passed-through command |
| cmdByte | output | 8 | Byte of the passed-through command |

## Verification
The bench uses the default parameters: a 6-bit code, an 8-bit bus and the default opcode values. With a 6-bit code, both ends of the drive-level range (codes 0 and 63) can be reached directly, and so can a data byte whose don't-care top bits are set. With the default opcodes, the bench can write the display and arming commands while contrast mode is armed, and so show that the armed state swallows them as data. The bench also covers every pairing of the two flags, to check the derived power-save state and the exit from it.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;
  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic loadCode;
    logic dispSet;
    logic dispClr;
    logic litSet;
    logic litClr;
    logic passCmd;
  } seqStrobes_t;
endpackage

// File: rtl/lcdseq_ctrl.sv
module lcdseq_ctrl
  import lcdseq_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter logic [BUS_W-1:0] OP_ARM      = 8'h81,
  parameter logic [BUS_W-1:0] OP_DISP_ON  = 8'hAF,
  parameter logic [BUS_W-1:0] OP_DISP_OFF = 8'hAE,
  parameter logic [BUS_W-1:0] OP_LIT_ON   = 8'hA5,
  parameter logic [BUS_W-1:0] OP_LIT_OFF  = 8'hA4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csActive,
  input  logic             wrStrobe,
  input  logic             rdStrobe,
  input  logic             a0,
  input  logic [BUS_W-1:0] dataIn,
  output seqStrobes_t      strobes,
  output logic             armed
);
  logic wrPrev;
  logic wrEvent;
  logic cmdEvent;

  assign wrEvent  = wrStrobe && !wrPrev && csActive && !rdStrobe;
  assign cmdEvent = wrEvent && !a0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPrev <= 1'b0;
      armed  <= 1'b0;
    end else begin
      wrPrev <= wrStrobe;
      if (cmdEvent) begin
        if (armed) armed <= 1'b0;
        else       armed <= (dataIn == OP_ARM);
      end
    end
  end

  always_comb begin
    strobes = '0;
    if (cmdEvent) begin
      if (armed)                     strobes.loadCode = 1'b1;
      else if (dataIn == OP_ARM)     strobes = '0;
      else if (dataIn == OP_DISP_ON) strobes.dispSet  = 1'b1;
      else if (dataIn == OP_DISP_OFF) strobes.dispClr = 1'b1;
      else if (dataIn == OP_LIT_ON)  strobes.litSet   = 1'b1;
      else if (dataIn == OP_LIT_OFF) strobes.litClr   = 1'b1;
      else                           strobes.passCmd  = 1'b1;
    end
  end

  // R3
  armed_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && cmdEvent) |=> !armed);

  // R5
  data_keeps_armed_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEvent && a0) |=> (armed == $past(armed)));
endmodule

// File: rtl/lcdseq_datapath.sv
module lcdseq_datapath
  import lcdseq_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CODE_W = 6,
  parameter logic [CODE_W-1:0] CODE_DEFAULT = 6'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic [BUS_W-1:0]  dataIn,
  output logic [CODE_W-1:0] contrastCode,
  output logic [CODE_W-1:0] driveLevel,
  output logic              displayOn,
  output logic              allLit,
  output logic              powerSave,
  output logic              oscEnable,
  output logic              supplyEnable,
  output logic              driversLow,
  output logic              cmdStrobe,
  output logic [BUS_W-1:0]  cmdByte
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      contrastCode <= CODE_DEFAULT;
      displayOn    <= 1'b0;
      allLit       <= 1'b0;
      cmdStrobe    <= 1'b0;
      cmdByte      <= '0;
    end else begin
      if (strobes.loadCode) contrastCode <= dataIn[CODE_W-1:0];
      if (strobes.dispSet)  displayOn <= 1'b1;
      if (strobes.dispClr)  displayOn <= 1'b0;
      if (strobes.litSet)   allLit <= 1'b1;
      if (strobes.litClr)   allLit <= 1'b0;
      cmdStrobe <= strobes.passCmd;
      if (strobes.passCmd)  cmdByte <= dataIn;
    end
  end

  assign driveLevel   = CODE_MAX - contrastCode;
  assign powerSave    = !displayOn && allLit;
  assign oscEnable    = !powerSave;
  assign supplyEnable = !powerSave;
  assign driversLow   = powerSave;

  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadCode |=> $stable(contrastCode));

  // R7
  disp_set_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.dispSet |=> displayOn);

  // R8
  save_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    powerSave |-> (!oscEnable && !supplyEnable && driversLow && !displayOn));
endmodule

// File: rtl/lcdseq_top.sv
module lcdseq_top
  import lcdseq_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CODE_W = 6,
  parameter logic [CODE_W-1:0] CODE_DEFAULT = 6'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csActive,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic              a0,
  input  logic [BUS_W-1:0]  dataIn,
  output logic [CODE_W-1:0] contrastCode,
  output logic [CODE_W-1:0] driveLevel,
  output logic              displayOn,
  output logic              allLit,
  output logic              powerSave,
  output logic              oscEnable,
  output logic              supplyEnable,
  output logic              driversLow,
  output logic              cmdStrobe,
  output logic [BUS_W-1:0]  cmdByte
);
  seqStrobes_t strobes;
  logic        armedSig;

  lcdseq_ctrl #(.BUS_W(BUS_W)) ctrlInst (
    .clk(clk), .rst(rst), .csActive(csActive), .wrStrobe(wrStrobe),
    .rdStrobe(rdStrobe), .a0(a0), .dataIn(dataIn),
    .strobes(strobes), .armed(armedSig)
  );

  lcdseq_datapath #(.BUS_W(BUS_W), .CODE_W(CODE_W), .CODE_DEFAULT(CODE_DEFAULT)) dpInst (
    .clk(clk), .rst(rst), .strobes(strobes), .dataIn(dataIn),
    .contrastCode(contrastCode), .driveLevel(driveLevel),
    .displayOn(displayOn), .allLit(allLit), .powerSave(powerSave),
    .oscEnable(oscEnable), .supplyEnable(supplyEnable), .driversLow(driversLow),
    .cmdStrobe(cmdStrobe), .cmdByte(cmdByte)
  );

  // R4
  no_pass_when_armed_chk: assert property (@(posedge clk) disable iff (rst)
    cmdStrobe |-> !$past(armedSig));
endmodule

// File: tb/lcdseq_top_test.sv
module lcdseq_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csActive = 1'b0;
  logic       wrStrobe = 1'b0;
  logic       rdStrobe = 1'b0;
  logic       a0 = 1'b0;
  logic [7:0] dataIn = '0;
  logic [5:0] contrastCode, driveLevel;
  logic       displayOn, allLit, powerSave, oscEnable, supplyEnable, driversLow;
  logic       cmdStrobe;
  logic [7:0] cmdByte;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] expQ[$];

  lcdseq_top uut (
    .clk(clk), .rst(rst), .csActive(csActive), .wrStrobe(wrStrobe),
    .rdStrobe(rdStrobe), .a0(a0), .dataIn(dataIn),
    .contrastCode(contrastCode), .driveLevel(driveLevel),
    .displayOn(displayOn), .allLit(allLit), .powerSave(powerSave),
    .oscEnable(oscEnable), .supplyEnable(supplyEnable), .driversLow(driversLow),
    .cmdStrobe(cmdStrobe), .cmdByte(cmdByte)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Monitor: compare every command strobe with the scoreboard queue
  always @(negedge clk) begin
    cycles++;
    if (!rst && cmdStrobe) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected strobe actual=%0d expected=none", cmdByte);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        if (cmdByte != e) begin
          fails++;
          $display("FAIL R9 actual=%0d expected=%0d", cmdByte, e);
        end
      end
    end
  end

  // Driver: one write; strobe held for holdCycles cycles
  task automatic writeByte(input logic isData, input logic [7:0] b,
                           input logic cs = 1'b1, input logic rd = 1'b0,
                           input int holdCycles = 1, input logic expectPass = 1'b0);
    if (expectPass) expQ.push_back(b);
    @(negedge clk);
    csActive = cs; rdStrobe = rd; a0 = isData; dataIn = b; wrStrobe = 1'b1;
    repeat (holdCycles) @(negedge clk);
    wrStrobe = 1'b0; csActive = 1'b0; rdStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkSave(input string req, input int ps);
    check({req, " powerSave"}, powerSave, ps);
    check({req, " oscEnable"}, oscEnable, !ps);
    check({req, " supplyEnable"}, supplyEnable, !ps);
    check({req, " driversLow"}, driversLow, ps);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 code", contrastCode, 32);
    check("R1 level", driveLevel, 31);
    check("R1 displayOn", displayOn, 0);
    check("R1 allLit", allLit, 0);
    checkSave("R1", 0);
    check("R1 cmdStrobe", cmdStrobe, 0);

    // R9 pass-through
    writeByte(1'b0, 8'h40, 1'b1, 1'b0, 1, 1'b1);
    writeByte(1'b0, 8'hE3, 1'b1, 1'b0, 1, 1'b1);

    // R3 contrast pair, top bits ignored; R6 level
    writeByte(1'b0, 8'h81);
    writeByte(1'b0, 8'hC5);
    check("R3 code", contrastCode, 5);
    check("R6 level", driveLevel, 58);
    writeByte(1'b0, 8'h30, 1'b1, 1'b0, 1, 1'b1); // R3 disarmed: next command passes

    // R4 armed swallows display-on and arm bytes
    writeByte(1'b0, 8'h81);
    writeByte(1'b0, 8'hAF);
    check("R4 code", contrastCode, 6'h2F);
    check("R4 displayOn", displayOn, 0);
    writeByte(1'b0, 8'h81);
    writeByte(1'b0, 8'h81);
    check("R4 code arm byte", contrastCode, 1);
    writeByte(1'b0, 8'h31, 1'b1, 1'b0, 1, 1'b1);

    // R5 data writes do not disturb armed mode
    writeByte(1'b0, 8'h81);
    writeByte(1'b1, 8'h3F);
    writeByte(1'b1, 8'h22);
    check("R5 code unchanged by data", contrastCode, 1);
    writeByte(1'b0, 8'h11);
    check("R5 code", contrastCode, 6'h11);

    // R6 extremes
    writeByte(1'b0, 8'h81);
    writeByte(1'b0, 8'h00);
    check("R6 level max", driveLevel, 63);
    writeByte(1'b0, 8'h81);
    writeByte(1'b0, 8'h3F);
    check("R6 level min", driveLevel, 0);

    // R2 cs low, rd high, held strobe
    writeByte(1'b0, 8'h81, 1'b0);
    writeByte(1'b0, 8'h12, 1'b1, 1'b0, 1, 1'b1);
    check("R2 cs low ignored", contrastCode, 63);
    writeByte(1'b0, 8'hA5, 1'b1, 1'b1);
    check("R2 rd high ignored", allLit, 0);
    writeByte(1'b0, 8'h13, 1'b1, 1'b0, 4, 1'b1);

    // R7 / R8 flags and power save
    writeByte(1'b0, 8'hAF);
    check("R7 displayOn set", displayOn, 1);
    checkSave("R8 on/off", 0);
    writeByte(1'b0, 8'hA5);
    check("R7 allLit set", allLit, 1);
    checkSave("R8 on/on", 0);
    writeByte(1'b0, 8'hAE);
    check("R7 displayOn clr", displayOn, 0);
    checkSave("R8 off/on", 1);
    writeByte(1'b0, 8'h81);
    writeByte(1'b0, 8'h0A);
    check("R10 code load in save", contrastCode, 10);
    writeByte(1'b0, 8'hA4);
    check("R7 allLit clr", allLit, 0);
    checkSave("R8 off/off", 0);
    check("R10 code kept", contrastCode, 10);
    check("R10 displayOn kept", displayOn, 0);

    repeat (3) @(negedge clk);
    check("R9 queue drained", expQ.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule